// File: doc/BRIEF.md
# Subroutine Call, Return and Software Interrupt Stack Sequencer

This block runs the stack side of a subroutine call, a return, a return from interrupt and a software interrupt on a 16-bit machine. Its stack lives in word-addressed memory and grows toward lower addresses. A decoder hands it one request together with the current program counter (PC), flag word (F) and stack pointer (SP), plus a 16-bit argument. The argument is an absolute target, a relative offset, or a vector in its low byte. The PC supplied is already the address of the next instruction.

Once the sequencer accepts a request it stays busy for exactly eight cycles. During that time it drives a synchronous memory port and emits write strobes for PC, F and SP with their new values. Calls and interrupts save PC and then F, and step SP down once after each write. Returns step SP up, reload F, step SP up again and then reload PC. The last cycle raises a done pulse. A return from interrupt also raises an interrupt-enable pulse in that cycle.

Top module: `stack_seq`

## Requirements
- R1: A push request (op 0 absolute call, op 1 relative call, op 4 software interrupt) writes PC to address SP. SP is then written as SP-1. F is then written to address SP-1. SP is then written as SP-2. The PC strobe comes after all of these. All SP arithmetic wraps modulo 2^16.
- R2: A pop request (op 2 return, op 3 return from interrupt) first writes SP as SP+1 and then reads address SP+1. It writes the data read to F, writes SP as SP+2, reads address SP+2, and finally loads PC with that second word. No memory write occurs.
- R3: Every accepted request keeps busy high for exactly 8 cycles. The first action comes in the cycle after the accepting edge. done and the PC strobe are high only in the 8th cycle, and busy is low in the cycle after it.
- R4: Op 0 loads PC with the argument.
- R5: Op 1 loads PC with PC plus the argument, taken as a two's-complement offset, modulo 2^16.
- R6: Op 4 loads PC with argument bits 7:0 zero-extended. Argument bits 15:8 have no effect.
- R7: F is written only by pop requests. The interrupt-enable pulse is raised only in the done cycle of op 3, never for op 2 or for any push.
- R8: A request presented while busy is high, including in the done cycle, is ignored. It changes neither the running sequence nor the idle state that follows.
- R9: Op codes 5, 6 and 7 are ignored. busy stays low and no strobe is raised.
- R10: After reset, busy, done and all memory and register strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 3 | 0 call absolute, 1 call relative, 2 return, 3 return from interrupt, 4 software interrupt |
| req_arg | input | 16 | Target, offset, or vector in bits 7:0 |
| pc_in | input | 16 | Address of the next instruction |
| f_in | input | 16 | Current flag word |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| pc_out | output | 16 | New PC value |
| pc_we | output | 1 | PC write strobe |
| f_out | output | 16 | New flag word |
| f_we | output | 1 | Flag write strobe |
| sp_out | output | 16 | New stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| ie_set | output | 1 | Re-enable hardware interrupts pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |

## Verification
Each action belongs to a fixed cycle index counted from the accepting edge.

- For a push, the two writes fall in cycles 1 and 4 and the SP strobes in cycles 2 and 5.
- For a pop, the SP strobes fall in cycles 1 and 4, the reads in 2 and 5, and the F strobe in 3.
- done, the PC strobe and any interrupt-enable pulse fall in cycle 8.
- busy must be low in cycle 9.

The bench samples every output at the falling edge of each of cycles 1 through 10 after acceptance. It logs the index of every strobe, then compares the logged values and the order of the indices against values computed from the request. Stray requests are injected in cycles 2 and 8 to show that they have no effect.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int W  = 16,
  parameter int VW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [2:0]   req_op,
  input  logic [W-1:0] req_arg,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] f_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] pc_out,
  output logic         pc_we,
  output logic [W-1:0] f_out,
  output logic         f_we,
  output logic [W-1:0] sp_out,
  output logic         sp_we,
  output logic         ie_set,
  output logic         busy,
  output logic         done
);
  localparam logic [2:0] OP_CALL  = 3'd0;
  localparam logic [2:0] OP_CALLR = 3'd1;
  localparam logic [2:0] OP_RET   = 3'd2;
  localparam logic [2:0] OP_RETI  = 3'd3;
  localparam logic [2:0] OP_INT   = 3'd4;
  localparam logic [2:0] LAST     = 3'd7;
  localparam logic [W-1:0] ONE    = W'(1);
  localparam logic [W-1:0] TWO    = W'(2);

  logic         busy_q;
  logic [2:0]   step_q, op_q;
  logic [W-1:0] pc_q, f_q, sp_q, arg_q;
  logic         accept, is_push;

  assign accept  = req_valid && !busy_q && (req_op <= OP_INT);
  assign is_push = (op_q == OP_CALL) || (op_q == OP_CALLR) || (op_q == OP_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      op_q   <= '0;
      pc_q   <= '0;
      f_q    <= '0;
      sp_q   <= '0;
      arg_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= '0;
      op_q   <= req_op;
      pc_q   <= pc_in;
      f_q    <= f_in;
      sp_q   <= sp_in;
      arg_q  <= req_arg;
    end else if (busy_q) begin
      step_q <= step_q + 3'd1;
      if (step_q == LAST) busy_q <= 1'b0;
      if (!is_push && step_q == 3'd5) pc_q <= mem_rdata;
    end
  end

  assign busy   = busy_q;
  assign done   = busy_q && (step_q == LAST);
  assign pc_we  = done;
  assign ie_set = done && (op_q == OP_RETI);

  assign mem_wr    = busy_q && is_push  && (step_q == 3'd0 || step_q == 3'd3);
  assign mem_rd    = busy_q && !is_push && (step_q == 3'd1 || step_q == 3'd4);
  assign mem_wdata = (step_q == 3'd0) ? pc_q : f_q;
  assign mem_addr  = is_push ? ((step_q == 3'd0) ? sp_q : sp_q - ONE)
                             : ((step_q == 3'd1) ? sp_q + ONE : sp_q + TWO);

  assign sp_we  = busy_q && (is_push ? (step_q == 3'd1 || step_q == 3'd4)
                                     : (step_q == 3'd0 || step_q == 3'd3));
  assign sp_out = is_push ? ((step_q == 3'd1) ? sp_q - ONE : sp_q - TWO)
                          : ((step_q == 3'd0) ? sp_q + ONE : sp_q + TWO);

  assign f_we  = busy_q && !is_push && (step_q == 3'd2);
  assign f_out = mem_rdata;

  always_comb begin
    case (op_q)
      OP_CALL:          pc_out = arg_q;
      OP_CALLR:         pc_out = pc_q + arg_q;
      OP_INT:           pc_out = {{(W-VW){1'b0}}, arg_q[VW-1:0]};
      OP_RET, OP_RETI:  pc_out = pc_q;
      default:          pc_out = pc_q;
    endcase
  end
endmodule

module stack_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic mem_wr,
  input logic mem_rd,
  input logic sp_we
);
  AST_WRITE_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (sp_we && !mem_wr)); // R1
  AST_READ_AFTER_INC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(sp_we)); // R2
  AST_EIGHT_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy, 7) && !$past(busy, 8))); // R3
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R9
endmodule

bind stack_seq stack_seq_chk chk_i (.*);

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [15:0] req_arg = '0, pc_in = '0, f_in = '0, sp_in = '0;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr, pc_we, f_we, sp_we, ie_set, busy, done;
  logic [15:0] mem_addr, mem_wdata, pc_out, f_out, sp_out;

  int checks = 0;
  int failures = 0;
  logic [15:0] mem [0:255];

  always #2.5 clk = ~clk;

  stack_seq dut_i (.*);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pc(input logic [2:0] op, input logic [15:0] arg, input logic [15:0] pc);
    case (op)
      3'd0: return arg;
      3'd1: return pc + arg;
      default: return {8'h00, arg[7:0]};
    endcase
  endfunction

  task automatic run_txn(input logic [2:0] op, input logic [15:0] arg, input logic [15:0] pc,
                         input logic [15:0] f, input logic [15:0] sp);
    bit push;
    logic [15:0] mf, mp;
    int nw, nsp, nrd, nf, npc, ndone, nie, busy9;
    int wc[2], sc[2], rc[2];
    logic [15:0] wa[2], wd[2], sv[2], ra[2];
    logic [15:0] fv, pv;
    int pcc, dc;
    push = (op == 3'd0 || op == 3'd1 || op == 3'd4);
    mf = 16'($urandom); mp = 16'($urandom);
    if (!push) begin
      mem[8'(sp + 16'd1)] = mf;
      mem[8'(sp + 16'd2)] = mp;
    end
    nw = 0; nsp = 0; nrd = 0; nf = 0; npc = 0; ndone = 0; nie = 0; busy9 = 0;
    pcc = 0; dc = 0; fv = '0; pv = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_arg = arg; pc_in = pc; f_in = f; sp_in = sp;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      if (k > 1) @(negedge clk);
      if (mem_wr) begin if (nw < 2) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; wc[nw] = k; end nw++; end
      if (mem_rd) begin if (nrd < 2) begin ra[nrd] = mem_addr; rc[nrd] = k; end nrd++; end
      if (sp_we) begin if (nsp < 2) begin sv[nsp] = sp_out; sc[nsp] = k; end nsp++; end
      if (f_we) begin fv = f_out; nf++; end
      if (pc_we) begin pv = pc_out; pcc = k; npc++; end
      if (done) begin dc = k; ndone++; end
      if (ie_set) nie++;
      if (k >= 9 && busy) busy9++;
      req_valid = 1'b0;
      if (k == 2 || k == 8) begin
        req_valid = 1'b1; req_op = 3'd0; req_arg = ~arg; pc_in = ~pc; f_in = ~f; sp_in = ~sp;
      end
    end
    chk(ndone == 1 && dc == 8, "R3 done cycle", 32'(dc), 32'd8);
    chk(npc == 1 && pcc == 8, "R3 pc strobe cycle", 32'(pcc), 32'd8);
    chk(busy9 == 0, "R8 busy after done with stray request", 32'(busy9), 32'd0);
    if (push) begin
      chk(nw == 2 && nsp == 2 && nrd == 0, "R1 strobe counts", 32'(nw*16+nsp), 32'h22);
      chk(wa[0] == sp && wd[0] == pc, "R1 first write", {wa[0], wd[0]}, {sp, pc});
      chk(wa[1] == 16'(sp - 16'd1) && wd[1] == f, "R1 second write", {wa[1], wd[1]}, {16'(sp - 16'd1), f});
      chk(sv[0] == 16'(sp - 16'd1) && sv[1] == 16'(sp - 16'd2), "R1 sp values", {sv[0], sv[1]},
          {16'(sp - 16'd1), 16'(sp - 16'd2)});
      chk(wc[0] < sc[0] && sc[0] < wc[1] && wc[1] < sc[1] && sc[1] < pcc, "R1 step order",
          32'(wc[0]*4096 + sc[0]*256 + wc[1]*16 + sc[1]), 32'h1245);
      chk(nf == 0 && nie == 0, "R7 no flag write or ie on push", 32'(nf*16+nie), 32'd0);
      if (op == 3'd0) chk(pv == exp_pc(op, arg, pc), "R4 absolute target", 32'(pv), 32'(exp_pc(op, arg, pc)));
      if (op == 3'd1) chk(pv == exp_pc(op, arg, pc), "R5 relative target", 32'(pv), 32'(exp_pc(op, arg, pc)));
      if (op == 3'd4) chk(pv == exp_pc(op, arg, pc), "R6 vector target", 32'(pv), 32'(exp_pc(op, arg, pc)));
    end else begin
      chk(nw == 0 && nsp == 2 && nrd == 2 && nf == 1, "R2 strobe counts",
          32'(nw*4096 + nsp*256 + nrd*16 + nf), 32'h0221);
      chk(sv[0] == 16'(sp + 16'd1) && sv[1] == 16'(sp + 16'd2), "R2 sp values", {sv[0], sv[1]},
          {16'(sp + 16'd1), 16'(sp + 16'd2)});
      chk(ra[0] == 16'(sp + 16'd1) && ra[1] == 16'(sp + 16'd2), "R2 read addresses", {ra[0], ra[1]},
          {16'(sp + 16'd1), 16'(sp + 16'd2)});
      chk(sc[0] < rc[0] && rc[0] < sc[1] && sc[1] < rc[1], "R2 step order",
          32'(sc[0]*4096 + rc[0]*256 + sc[1]*16 + rc[1]), 32'h1245);
      chk(fv == mf, "R2 restored flags", 32'(fv), 32'(mf));
      chk(pv == mp, "R2 restored pc", 32'(pv), 32'(mp));
      chk(nie == ((op == 3'd3) ? 1 : 0), "R7 interrupt enable pulse", 32'(nie), (op == 3'd3) ? 32'd1 : 32'd0);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_wr && !mem_rd && !sp_we && !pc_we && !f_we && !ie_set,
        "R10 reset idle", {busy, done, mem_wr, mem_rd, sp_we, pc_we, f_we, ie_set}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after release", {busy, done}, 32'd0);

    run_txn(3'd0, 16'h1234, 16'h0100, 16'h00a5, 16'h0080);
    run_txn(3'd0, 16'hbeef, 16'h0200, 16'h0003, 16'h0000);
    run_txn(3'd1, 16'hfff0, 16'h0008, 16'h0001, 16'h0040);
    run_txn(3'd1, 16'h7fff, 16'hff00, 16'h0002, 16'h0050);
    run_txn(3'd4, 16'habcd, 16'h3000, 16'h000f, 16'h0060);
    run_txn(3'd4, 16'hff00, 16'h3000, 16'h000f, 16'h0060);
    run_txn(3'd2, 16'h0000, 16'h1111, 16'h2222, 16'h007e);
    run_txn(3'd3, 16'h0000, 16'h1111, 16'h2222, 16'hfffe);
    run_txn(3'd2, 16'h0000, 16'h0000, 16'h0000, 16'hffff);

    for (int op = 5; op <= 7; op++) begin
      int act;
      act = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        req_valid = 1'b0;
        if (busy || mem_wr || mem_rd || sp_we || pc_we || f_we || done || ie_set) act++;
      end
      chk(act == 0, "R9 unsupported op ignored", 32'(act), 32'd0);
    end

    for (int n = 0; n < 60; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 5);
      run_txn(op, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule